// File: doc/BRIEF.md
# Dual-Result Serial Output Port

This block moves a pair of 16-bit conversion results off chip over one serial data line. Each time a new pair is latched, the two words are packed into a 32-bit frame: the channel picked by an order input goes in the upper half, and the frame leaves MSB first. The port can act as clock master or as clock slave. As master it makes its own serial clock by dividing the system clock, and it drives a frame strobe. As slave it shifts on edges of a serial clock supplied by the host, and that clock is gated by chip-select.

In master mode a frame starts when a new result is latched (read after conversion), or when a conversion starts (read during conversion), in which case the port sends the previously latched pair. The frame strobe is held active for the whole frame, except for one low half-period of the serial clock at the channel boundary. In slave mode the register takes in a serial input at its bottom end as it shifts. Several ports can therefore be chained, and a slave flags a read that a newer result has cut short. All configuration inputs are static levels. They are changed only while chip-select is high.

Top module: `dual_result_serializer`

## Requirements
- R1: A frame is 32 bits sent MSB first. With `a_first`=1 the upper 16 bits are `res_a` and the lower 16 are `res_b`. With `a_first`=0 the halves swap.
- R2: In master mode the serial clock period is (4 << `div_sel`) system clocks: 4, 8, 16 or 32 for codes 0 to 3. A frame has exactly 32 rising edges of the non-inverted clock, and `sdout` changes only on its falling edges.
- R3: In master mode the frame strobe is active from the start of a frame to its end. The one exception is the low half-period before the 17th rising clock edge, where it is inactive. Active is high when `sync_inv`=0 and low when `sync_inv`=1. Outside a frame the strobe is inactive.
- R4: `sclk_inv`=1 inverts the master clock output, which then idles high. In slave mode it moves the active edge of `sclk_in` from rising to falling.
- R5: With `rd_during`=0, a master frame starts in the cycle after `res_valid` and carries the pair presented with that pulse.
- R6: With `rd_during`=1, a master frame starts in the cycle after `conv_start` and carries the pair latched by the last earlier `res_valid`.
- R7: In slave mode a `res_valid` loads the frame and puts its MSB on `sdout`. Each active edge of `sclk_in` while `cs_n`=0 shifts the register one place and samples `sdin` into its bottom. After 32 active edges, `sdout` shows the `sdin` bit taken at the first edge.
- R8: In slave mode, a `res_valid` that arrives after 1 to 31 active edges of the current frame raises `rd_err` high for exactly one cycle and loads the new pair. A `res_valid` that arrives after 0 or 32 edges leaves `rd_err` low.
- R9: `cs_n`=1 ends any master frame and blocks new ones. `sclk_oe` and `sync_oe` are high only in master mode with `cs_n`=0. `sdout_oe` is high only when both `cs_n` and `rd_n` are 0.
- R10: After reset, `rd_err` is 0, no frame is active, and the frame register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse: a new result pair is present |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| conv_start | input | 1 | One-cycle pulse: a conversion begins |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| slave_mode | input | 1 | 0 = port makes the clock, 1 = host clock |
| a_first | input | 1 | Channel order select |
| sync_inv | input | 1 | Frame strobe polarity |
| sclk_inv | input | 1 | Serial clock inversion |
| rd_during | input | 1 | Master read timing: 1 = during conversion |
| div_sel | input | 2 | Master clock divider code |
| sclk_in | input | 1 | Host serial clock (slave) |
| sdin | input | 1 | Chain serial input (slave) |
| sclk_out | output | 1 | Generated serial clock (master) |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| sync_out | output | 1 | Frame strobe (master) |
| sync_oe | output | 1 | Drive enable for `sync_out` |
| sdout | output | 1 | Serial data |
| sdout_oe | output | 1 | Drive enable for `sdout` |
| rd_err | output | 1 | Incomplete-read pulse (slave) |

## Verification
The assertions take several things for granted. `res_valid` never comes in two consecutive cycles. The configuration inputs do not change while `cs_n` is low. The host clock is slow compared with the system clock: each level lasts several cycles, so the two-stage synchronizer misses no edge, and `sdin` is stable around the active edge. The bench applies every configuration change with `cs_n` high. It keeps `sclk_in` at each level for eight system clocks, sets `sdin` during the inactive phase, and spaces its result and conversion pulses far enough apart that a master frame never overlaps a new trigger.

// File: rtl/drs_pkg.sv
// Shared sizes and helpers for the dual-result serializer.
// Assumes two equal-width results packed into one frame.
package drs_pkg;
    parameter int RES_W   = 16;
    parameter int FRAME_W = 2 * RES_W;
    localparam int BIT_W  = $clog2(FRAME_W);
    localparam int CNT_W  = $clog2(FRAME_W + 1);

    typedef logic [FRAME_W-1:0] frame_t;

    // Put the selected channel in the upper half of the frame
    function automatic frame_t pack_pair(input logic a_hi,
                                         input logic [RES_W-1:0] a,
                                         input logic [RES_W-1:0] b);
        return a_hi ? {a, b} : {b, a};
    endfunction
endpackage

// File: rtl/drs_mdiv.sv
// Master clock divider: pulses tick once every (BASE << sel) cycles while run is high.
// Assumes sel is static during a run; the count restarts whenever run drops.
module drs_mdiv #(
    parameter int BASE = 2,
    parameter int CW   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam logic [CW-1:0] BASE_V = CW'(BASE);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = BASE_V << sel;
    assign tick = run && (cnt == lim - 1'b1);

    // Half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assert_div_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
    assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim));
endmodule

// File: rtl/drs_sreg.sv
// Frame shift register: parallel load has priority over shift; shifts left, filling from sin.
// Assumes load and shift are single-cycle strobes.
module drs_sreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    // Load or shift the frame
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], sin};
    end

    assert_shift_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (q[0] == $past(sin)));
    assert_shift_move_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (q[W-1] == $past(q[W-2])));
endmodule

// File: rtl/dual_result_serializer.sv
// Serial output port for a latched pair of results, master or slave clocked.
// Assumes configuration inputs change only while cs_n is high and that
// sclk_in levels last several clk cycles.
module dual_result_serializer
    import drs_pkg::*;
#(
    parameter int DIV_BASE = 2,
    parameter int DIV_CW   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    input  logic             conv_start,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             slave_mode,
    input  logic             a_first,
    input  logic             sync_inv,
    input  logic             sclk_inv,
    input  logic             rd_during,
    input  logic [1:0]       div_sel,
    input  logic             sclk_in,
    input  logic             sdin,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             sdout,
    output logic             sdout_oe,
    output logic             rd_err
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
    localparam logic [BIT_W-1:0] MID_BIT  = BIT_W'(RES_W);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    frame_t           latch_q, now_pair, load_val, shreg;
    logic             m_act, m_ph, tick, m_start;
    logic [BIT_W-1:0] m_bits;
    logic             s1, s2, s3, act_edge, s_load;
    logic [CNT_W-1:0] s_cnt;
    logic             shift_en, load_en, rd_err_q;

    assign now_pair = pack_pair(a_first, res_a, res_b);
    assign m_start  = !slave_mode && !cs_n && !m_act &&
                      (rd_during ? conv_start : res_valid);
    assign s_load   = slave_mode && res_valid;
    assign act_edge = slave_mode && !cs_n && s2 && !s3;
    assign load_en  = m_start || s_load;
    assign load_val = (!slave_mode && rd_during) ? latch_q : now_pair;
    assign shift_en = (m_act && tick && m_ph) || act_edge;

    drs_mdiv #(.BASE(DIV_BASE), .CW(DIV_CW)) i_mdiv (
        .clk(clk), .rst_n(rst_n), .run(m_act), .sel(div_sel), .tick(tick)
    );

    drs_sreg #(.W(FRAME_W)) i_sreg (
        .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_val),
        .shift(shift_en), .sin(slave_mode ? sdin : 1'b0), .q(shreg)
    );

    // Hold the most recent result pair for read-during-conversion
    always_ff @(posedge clk) begin
        if (!rst_n)         latch_q <= '0;
        else if (res_valid) latch_q <= now_pair;
    end

    // Master frame sequencer: clock phase and bit position
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            m_act  <= 1'b0;
            m_ph   <= 1'b0;
            m_bits <= '0;
        end else if (m_start) begin
            m_act  <= 1'b1;
            m_ph   <= 1'b0;
            m_bits <= '0;
        end else if (m_act && tick) begin
            m_ph <= !m_ph;
            if (m_ph) begin
                if (m_bits == LAST_BIT) m_act  <= 1'b0;
                else                    m_bits <= m_bits + 1'b1;
            end
        end
    end

    // Synchronize the host clock (with inversion) for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b000;
        else        {s1, s2, s3} <= {sclk_in ^ sclk_inv, s1, s2};
    end

    // Slave edge count within the current frame, saturating at a full frame
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n || s_load)           s_cnt <= '0;
        else if (act_edge && s_cnt != FULL_CNT) s_cnt <= s_cnt + 1'b1;
    end

    // Incomplete-read flag: new result arrives during a partial slave read
    always_ff @(posedge clk) begin
        if (!rst_n) rd_err_q <= 1'b0;
        else        rd_err_q <= s_load && (s_cnt != '0) && (s_cnt != FULL_CNT);
    end

    assign rd_err   = rd_err_q;
    assign sdout    = shreg[FRAME_W-1];
    assign sdout_oe = !cs_n && !rd_n;
    assign sclk_oe  = !slave_mode && !cs_n;
    assign sync_oe  = !slave_mode && !cs_n;
    assign sclk_out = m_ph ^ sclk_inv;
    assign sync_out = (m_act && !(m_bits == MID_BIT && !m_ph)) ^ sync_inv;

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !m_act);
    assert_rderr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |=> !rd_err);
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !m_act |-> (sclk_out == sclk_inv));
    assert_strobe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !m_act |-> (sync_out == sync_inv));
    assert_edge_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_cnt <= FULL_CNT);
endmodule

// File: tb/test_dual_result_serializer.sv
module test_dual_result_serializer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid = 0, conv_start = 0, cs_n = 1, rd_n = 1;
    logic slave_mode = 0, a_first = 1, sync_inv = 0, sclk_inv = 0, rd_during = 0;
    logic [1:0] div_sel = 0;
    logic sclk_in = 0, sdin = 0;
    logic [15:0] res_a = 0, res_b = 0;
    logic sclk_out, sclk_oe, sync_out, sync_oe, sdout, sdout_oe, rd_err;

    int tests = 0, fails = 0;
    logic [31:0] exp_q[$];
    int cyc = 0, last_rise = 0, mon_bits = 0, idle = 0, rise_total = 0, exp_period = 4;
    logic mon_prev = 0, inact = 0;
    logic [31:0] mon_word = 0;

    always #2.5 clk = ~clk;

    dual_result_serializer i_dual_result_serializer (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: assemble master frames, check period and strobe, compare against scoreboard
    always @(negedge clk) begin
        logic eff, act;
        cyc++;
        eff = sclk_out ^ sclk_inv;
        act = sync_out ^ sync_inv;
        if (!act) begin idle++; inact = 1; end else idle = 0;
        if (idle > 40) mon_bits = 0;
        if (sclk_oe && eff && !mon_prev) begin
            rise_total++;
            if (mon_bits > 0) begin
                chk(cyc - last_rise == exp_period, "R2 period", cyc - last_rise, exp_period);
                chk(inact == (mon_bits == 16), "R3 mid strobe", inact, mon_bits == 16);
            end
            inact = 0;
            last_rise = cyc;
            mon_word = {mon_word[30:0], sdout};
            mon_bits++;
            if (mon_bits == 32) begin
                if (exp_q.size() == 0) chk(0, "R1 unexpected frame", mon_word, 0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(mon_word == e, "R1 frame data", mon_word, e);
                end
                mon_bits = 0;
            end
        end
        mon_prev = eff;
    end

    task automatic tick_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: present a result pair, push the expected master frame
    task automatic send_result(input logic [15:0] a, input logic [15:0] b, input bit push);
        res_a = a; res_b = b; res_valid = 1;
        if (push) exp_q.push_back(a_first ? {a, b} : {b, a});
        tick_n(1);
        res_valid = 0;
    endtask

    task automatic config_master(input logic [1:0] d, input logic af, input logic si, input logic ci, input logic rdc);
        cs_n = 1; tick_n(2);
        slave_mode = 0; div_sel = d; a_first = af; sync_inv = si; sclk_inv = ci; rd_during = rdc;
        exp_period = 4 << d;
        tick_n(2); cs_n = 0; rd_n = 0; tick_n(2);
    endtask

    // One slave bit: check sdout, present sdin, make the active edge
    task automatic slave_bit(input logic exp_bit, input logic din, input string tag);
        sdin = din;
        sclk_in = sclk_inv; tick_n(8);
        chk(sdout == exp_bit, tag, sdout, exp_bit);
        sclk_in = ~sclk_inv; tick_n(8);
        sclk_in = sclk_inv;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [7:0] pat;
        int r0;
        tick_n(4);
        rst_n = 1; tick_n(1);
        // R10 reset state
        chk(rd_err == 0, "R10 rd_err", rd_err, 0);
        chk(sync_out == 0 && sclk_out == 0, "R10 idle outputs", {sync_out, sclk_out}, 0);
        chk(sclk_oe == 0 && sdout_oe == 0, "R9 enables with cs_n high", {sclk_oe, sdout_oe}, 0);
        cs_n = 0; rd_n = 0; tick_n(1);
        chk(sdout == 0, "R10 frame register zero", sdout, 0);

        // R5 after-convert, div 0, A first
        config_master(0, 1, 0, 0, 0);
        chk(sclk_oe && sync_oe && sdout_oe, "R9 master enables", {sclk_oe, sync_oe, sdout_oe}, 3'b111);
        send_result(16'hA5C3, 16'h1234, 1);
        tick_n(32 * 4 + 40);
        chk(exp_q.size() == 0, "R5 frame after result", exp_q.size(), 0);
        chk(sync_out == 0, "R3 strobe idle after frame", sync_out, 0);

        // R2/R3/R4 div 3, B first, inverted strobe and clock
        config_master(3, 0, 1, 1, 0);
        chk(sclk_out == 1 && sync_out == 1, "R4 inverted idle levels", {sclk_out, sync_out}, 2'b11);
        send_result(16'h8001, 16'h7FFE, 1);
        tick_n(32 * 32 + 40);
        chk(exp_q.size() == 0, "R2 div3 frame done", exp_q.size(), 0);

        // R2 div 1 and div 2
        for (int d = 1; d < 3; d++) begin
            config_master(d[1:0], 1, 0, 0, 0);
            send_result(16'h0F0F + d[15:0], 16'hF0F0, 1);
            tick_n(32 * (4 << d) + 40);
            chk(exp_q.size() == 0, "R2 div frame done", exp_q.size(), 0);
        end

        // R6 read during conversion: sends previous pair (div2 loop: a=0F11, b=F0F0, A first)
        config_master(0, 1, 0, 0, 1);
        exp_q.push_back({16'h0F11, 16'hF0F0});
        conv_start = 1; tick_n(1); conv_start = 0;
        tick_n(3);
        send_result(16'hBEEF, 16'hCAFE, 0);
        tick_n(32 * 4 + 40);
        chk(exp_q.size() == 0, "R6 previous pair sent", exp_q.size(), 0);
        exp_q.push_back({16'hBEEF, 16'hCAFE});
        conv_start = 1; tick_n(1); conv_start = 0;
        tick_n(32 * 4 + 40);
        chk(exp_q.size() == 0, "R6 latched pair sent", exp_q.size(), 0);

        // R9 abort on cs_n high, and no start while cs_n high
        config_master(1, 1, 0, 0, 0);
        send_result(16'h1111, 16'h2222, 0);
        tick_n(40);
        cs_n = 1; tick_n(2);
        chk(sclk_oe == 0 && sync_out == 0, "R9 abort", {sclk_oe, sync_out}, 0);
        tick_n(60);
        r0 = rise_total;
        send_result(16'h3333, 16'h4444, 0);
        cs_n = 0; tick_n(300);
        chk(rise_total == r0, "R9 no frame while deselected", rise_total - r0, 0);
        rd_n = 1; tick_n(1);
        chk(sdout_oe == 0, "R9 rd_n gates data", sdout_oe, 0);
        rd_n = 0; tick_n(1);
        chk(sdout_oe == 1, "R9 data enabled", sdout_oe, 1);

        // R7/R1 slave, rising edge, daisy chain
        cs_n = 1; tick_n(2);
        slave_mode = 1; sclk_inv = 0; sclk_in = 0; a_first = 1; tick_n(6);
        cs_n = 0; tick_n(2);
        chk(sclk_oe == 0 && sync_oe == 0, "R9 slave enables", {sclk_oe, sync_oe}, 0);
        w = {16'hC3A5, 16'h5A3C};
        pat = 8'b1011_0010;
        send_result(16'hC3A5, 16'h5A3C, 0);
        for (int i = 0; i < 40; i++)
            slave_bit(i < 32 ? w[31 - i] : pat[7 - (i - 32)], i < 8 ? pat[7 - i] : 1'b0, "R7 slave stream");

        // R4 slave falling edge, B first
        cs_n = 1; tick_n(2);
        sclk_inv = 1; sclk_in = 1; a_first = 0; tick_n(6);
        cs_n = 0; tick_n(2);
        w = {16'h00FF, 16'h9669};
        send_result(16'h9669, 16'h00FF, 0);
        for (int i = 0; i < 32; i++) slave_bit(w[31 - i], 1'b0, "R4 slave inverted clock");

        // R8 incomplete read error
        chk(rd_err == 0, "R8 no error after full read", rd_err, 0);
        send_result(16'hAAAA, 16'h5555, 0);
        for (int i = 0; i < 5; i++) slave_bit(i[0] ? 1'b1 : 1'b0, 1'b0, "R8 partial read");
        send_result(16'h8123, 16'h0000, 0);
        chk(rd_err == 1, "R8 error pulse", rd_err, 1);
        tick_n(1);
        chk(rd_err == 0, "R8 pulse one cycle", rd_err, 0);
        chk(sdout == 1'b0, "R8 new pair loaded", sdout, 0);
        send_result(16'h8123, 16'h0000, 0);
        chk(rd_err == 0, "R8 no error at zero edges", rd_err, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule